// File: doc/BRIEF.md
# Interrupt Redirection Router

This block sits on the I/O side of a multiprocessor interrupt system. It watches 24 interrupt request lines. Each line has its own entry in a programmable redirection table. An entry holds a vector, a service priority, a destination CPU set, a target-selection mode and a mask bit. A rising edge on a line makes it pending. The router then turns the pending request into one delivery message on a valid/ready port. The message carries the vector and a one-hot-per-CPU target mask, and the CPU-local units take their share from it.

Software programs the table through a simple write port, one whole entry per write. In fixed mode the message goes to every CPU named in the destination set, which may be one CPU, a subset or all of them. In lowest-priority mode the router reads the task priority that each CPU reports. It sends the message to the single candidate CPU whose task priority is lowest. The order in which lines are served comes from the programmed priority field and not from the line number.

Top module: `irq_redirect_router`

## Requirements
- R1: After reset every table entry is masked and `msg_valid` is low; no line is delivered until its entry has been written unmasked.
- R2: A rising edge on `irq_in[i]` sets the pending flag of line i; a line held high produces only one message.
- R3: A write with `cfg_we` high stores `cfg_wdata` into entry `cfg_idx`, laid out as vector [7:0], priority [11:8], destination mask [15:12] (bit c selects CPU c), mode [16] (0 fixed, 1 lowest task priority) and mask [17] (1 masked); an index of 24 or more changes no entry.
- R4: Among pending, unmasked lines the one with the highest priority field is delivered first; on equal priority the lower line index wins.
- R5: In fixed mode `msg_targets` equals the entry's destination mask exactly (single CPU, subset or broadcast).
- R6: In lowest mode `msg_targets` is one-hot and selects the CPU in the destination mask with the smallest `cpu_tpr` value (CPU c at bits [4c+3:4c]); on equal values the lower CPU index wins.
- R7: A masked line that fires stays pending and is delivered once its entry is unmasked.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_vector` and `msg_targets` hold steady, even if the table or the task priorities change.
- R9: A handshake (`msg_valid` and `msg_ready` high at a clock edge) clears that line's pending flag and drops `msg_valid` for one cycle; the next pending line is offered on the following edge.
- R10: A new rising edge on the line being delivered, in the same cycle as its handshake, keeps the line pending and yields a second message.
- R11: An unmasked entry with an empty destination mask is never delivered; its line stays pending until a destination is written.
- R12: With an edge sampled at clock edge k, `msg_valid` rises after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 24 | Interrupt request lines, edge sensitive |
| cfg_we | input | 1 | Table entry write enable |
| cfg_idx | input | 5 | Entry index for the write |
| cfg_wdata | input | 18 | Entry contents (layout in R3) |
| cpu_tpr | input | 16 | Task priority of each CPU, 4 bits per CPU |
| msg_valid | output | 1 | Delivery message is offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Vector of the offered message |
| msg_targets | output | 4 | One bit per CPU that receives the message |

## Verification
The two functions that can land in one cycle are the clearing of a line's pending flag at a handshake and a new rising edge that sets the same flag. The bench raises the line at the same time as it asserts `msg_ready`. It expects `msg_valid` to drop for exactly one cycle and the same vector to come back on the next edge. A lost second message or a message that never drops counts as a failure. A second overlap, a table rewrite while a message is held, is judged by requiring the held vector and targets to stay unchanged.

// File: rtl/irr_pkg.sv
package irr_pkg;

    localparam int CPU_N  = 4;
    localparam int VEC_W  = 8;
    localparam int PRIO_W = 4;
    localparam int TPR_W  = 4;

    typedef enum logic {
        DLV_FIXED  = 1'b0,
        DLV_LOWEST = 1'b1
    } dlv_mode_e;

    // Packed MSB first: mask, mode, destination, priority, vector
    typedef struct packed {
        logic               masked;
        dlv_mode_e          mode;
        logic [CPU_N-1:0]   dest;
        logic [PRIO_W-1:0]  prio;
        logic [VEC_W-1:0]   vec;
    } rte_t;

    localparam rte_t RTE_RESET = '{
        masked: 1'b1,
        mode:   DLV_FIXED,
        dest:   '0,
        prio:   '0,
        vec:    '0
    };

endpackage

// File: rtl/irr_table.sv
module irr_table
    import irr_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  rte_t             wr_data,
    output rte_t             entries [NUM_LINES]
);

    rte_t tab_d [NUM_LINES];
    rte_t tab_q [NUM_LINES];

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            tab_d[i] = tab_q[i];
            // An index beyond the table matches no entry
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                tab_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LINES; i++) begin
            if (!rst_n) tab_q[i] <= RTE_RESET;
            else        tab_q[i] <= tab_d[i];
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            entries[i] = tab_q[i];
        end
    end

endmodule

// File: rtl/irr_line_arb.sv
module irr_line_arb
    import irr_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] eligible,
    input  rte_t                 entries [NUM_LINES],
    output logic                 found,
    output logic [IDX_W-1:0]     grant_idx
);

    logic [PRIO_W-1:0] best_prio;

    // Strictly greater replaces the holder, so equal priority keeps the lower index
    always_comb begin
        found     = 1'b0;
        grant_idx = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (eligible[i] && (!found || (entries[i].prio > best_prio))) begin
                found     = 1'b1;
                grant_idx = IDX_W'(i);
                best_prio = entries[i].prio;
            end
        end
    end

endmodule

// File: rtl/irr_cpu_pick.sv
module irr_cpu_pick
    import irr_pkg::*;
(
    input  rte_t                   entry,
    input  logic [CPU_N*TPR_W-1:0] tpr_flat,
    output logic [CPU_N-1:0]       targets
);

    logic [TPR_W-1:0] tpr [CPU_N];
    logic [CPU_N-1:0] lowest_oh;
    logic [TPR_W-1:0] best_tpr;
    logic             any;

    genvar c;
    generate
        for (c = 0; c < CPU_N; c++) begin : g_tpr
            assign tpr[c] = tpr_flat[c*TPR_W +: TPR_W];
        end
    endgenerate

    always_comb begin
        lowest_oh = '0;
        best_tpr  = '0;
        any       = 1'b0;
        for (int k = 0; k < CPU_N; k++) begin
            if (entry.dest[k] && (!any || (tpr[k] < best_tpr))) begin
                any       = 1'b1;
                best_tpr  = tpr[k];
                lowest_oh = '0;
                lowest_oh[k] = 1'b1;
            end
        end
    end

    always_comb begin
        if (entry.mode == DLV_LOWEST) targets = lowest_oh;
        else                          targets = entry.dest;
    end

endmodule

// File: rtl/irq_redirect_router.sv
module irq_redirect_router
    import irr_pkg::*;
#(
    parameter int NUM_LINES = 24,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int ENTRY_W  = $bits(rte_t),
    localparam int TPR_ALL  = CPU_N * TPR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [ENTRY_W-1:0]   cfg_wdata,
    input  logic [TPR_ALL-1:0]   cpu_tpr,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [VEC_W-1:0]     msg_vector,
    output logic [CPU_N-1:0]     msg_targets
);

    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] irq_prev;
        logic                 valid;
        logic [VEC_W-1:0]     vec;
        logic [CPU_N-1:0]     tgt;
        logic [IDX_W-1:0]     sel;
        logic                 dyn;
    } state_t;

    state_t s_d, s_q;

    rte_t                 entries [NUM_LINES];
    logic [NUM_LINES-1:0] eligible;
    logic                 found;
    logic [IDX_W-1:0]     grant_idx;
    logic [CPU_N-1:0]     pick_tgt;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] clr;

    irr_table #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (rte_t'(cfg_wdata)),
        .entries (entries)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_elig
            assign eligible[g] = s_q.pend[g] && !entries[g].masked && (|entries[g].dest);
        end
    endgenerate

    irr_line_arb #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_arb (
        .eligible  (eligible),
        .entries   (entries),
        .found     (found),
        .grant_idx (grant_idx)
    );

    irr_cpu_pick u_pick (
        .entry    (entries[grant_idx]),
        .tpr_flat (cpu_tpr),
        .targets  (pick_tgt)
    );

    always_comb begin
        s_d        = s_q;
        rise       = irq_in & ~s_q.irq_prev;
        s_d.irq_prev = irq_in;
        clr        = '0;
        if (s_q.valid && msg_ready) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (s_q.sel == IDX_W'(i)) clr[i] = 1'b1;
            end
            s_d.valid = 1'b0;
        end else if (!s_q.valid && found) begin
            s_d.valid = 1'b1;
            s_d.vec   = entries[grant_idx].vec;
            s_d.tgt   = pick_tgt;
            s_d.sel   = grant_idx;
            s_d.dyn   = (entries[grant_idx].mode == DLV_LOWEST);
        end
        // A fresh edge in the clearing cycle wins over the clear
        s_d.pend = (s_q.pend & ~clr) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign msg_valid   = s_q.valid;
    assign msg_vector  = s_q.vec;
    assign msg_targets = s_q.tgt;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_targets))); // R8

    AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid); // R9

    AST_HELD_LINE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> s_q.pend[s_q.sel]); // R9

    AST_LOWEST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && s_q.dyn) |-> ($countones(msg_targets) == 1)); // R6

    AST_TARGETS_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_targets != '0)); // R11

endmodule

// File: tb/sim_irq_redirect_router.sv
module sim_irq_redirect_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] irq = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [17:0] cfg_wdata = '0;
    logic [15:0] tpr = '0;
    logic        msg_ready = 1'b0;
    logic        msg_valid;
    logic [7:0]  msg_vector;
    logic [3:0]  msg_targets;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    irq_redirect_router u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq),
        .cfg_we      (cfg_we),
        .cfg_idx     (cfg_idx),
        .cfg_wdata   (cfg_wdata),
        .cpu_tpr     (tpr),
        .msg_valid   (msg_valid),
        .msg_ready   (msg_ready),
        .msg_vector  (msg_vector),
        .msg_targets (msg_targets)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected below 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [17:0] ent(input bit msk, input bit dyn, input logic [3:0] dest,
                                        input logic [3:0] pr, input logic [7:0] v);
        return {msk, dyn, dest, pr, v};
    endfunction

    task automatic wr(input int idx, input logic [17:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_idx = idx[4:0];
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int ln);
        @(negedge clk);
        irq[ln] = 1'b1;
        @(negedge clk);
        irq[ln] = 1'b0;
    endtask

    task automatic accept(input logic [7:0] ev, input logic [3:0] et, input string req);
        int w = 0;
        while (!msg_valid && w < 20) begin
            @(negedge clk);
            w++;
        end
        check(msg_valid == 1'b1, req, "valid", int'(msg_valid), 1);
        check(msg_vector == ev, req, "vector", int'(msg_vector), int'(ev));
        check(msg_targets == et, req, "targets", int'(msg_targets), int'(et));
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic quiet(input int n, input string req);
        bit seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(!seen, req, "no message", int'(seen), 0);
    endtask

    task automatic t_reset_mask;
        check(msg_valid == 1'b0, "R1", "valid after reset", int'(msg_valid), 0);
        pulse(5);
        quiet(4, "R1");
        wr(5, ent(0, 0, 4'b0001, 4'd1, 8'h25));
        accept(8'h25, 4'b0001, "R7");
    endtask

    task automatic t_latency_level;
        wr(6, ent(0, 0, 4'b0010, 4'd1, 8'h36));
        @(negedge clk);
        irq[6] = 1'b1;
        @(negedge clk);
        check(msg_valid == 1'b0, "R12", "valid one edge after", int'(msg_valid), 0);
        @(negedge clk);
        check(msg_valid == 1'b1, "R12", "valid two edges after", int'(msg_valid), 1);
        accept(8'h36, 4'b0010, "R12");
        quiet(6, "R2");
        irq[6] = 1'b0;
    endtask

    task automatic t_fixed;
        wr(1, ent(0, 0, 4'b1010, 4'd2, 8'h31));
        wr(2, ent(0, 0, 4'b1111, 4'd2, 8'h32));
        wr(7, ent(0, 0, 4'b0100, 4'd2, 8'h37));
        pulse(1);
        accept(8'h31, 4'b1010, "R5");
        pulse(2);
        accept(8'h32, 4'b1111, "R5");
        pulse(7);
        accept(8'h37, 4'b0100, "R5");
    endtask

    task automatic t_priority;
        wr(3, ent(0, 0, 4'b0001, 4'd2, 8'h43));
        wr(10, ent(0, 0, 4'b0001, 4'd9, 8'h4A));
        wr(20, ent(0, 0, 4'b0001, 4'd9, 8'h54));
        @(negedge clk);
        irq[3] = 1'b1; irq[10] = 1'b1; irq[20] = 1'b1;
        @(negedge clk);
        irq[3] = 1'b0; irq[10] = 1'b0; irq[20] = 1'b0;
        accept(8'h4A, 4'b0001, "R4");
        accept(8'h54, 4'b0001, "R4");
        accept(8'h43, 4'b0001, "R4");
    endtask

    task automatic t_lowest;
        tpr = {4'd5, 4'd1, 4'd7, 4'd1};
        wr(8, ent(0, 1, 4'b1111, 4'd1, 8'h48));
        wr(9, ent(0, 1, 4'b1110, 4'd1, 8'h49));
        pulse(8);
        accept(8'h48, 4'b0001, "R6");
        pulse(9);
        accept(8'h49, 4'b0100, "R6");
        tpr = {4'd5, 4'd9, 4'd7, 4'd1};
        pulse(9);
        accept(8'h49, 4'b1000, "R6");
    endtask

    task automatic t_hold;
        bit moved = 1'b0;
        wr(11, ent(0, 0, 4'b0011, 4'd1, 8'h5B));
        pulse(11);
        @(negedge clk);
        wr(11, ent(0, 1, 4'b1100, 4'd1, 8'h77));
        tpr = 16'h0000;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (!msg_valid || msg_vector != 8'h5B || msg_targets != 4'b0011) moved = 1'b1;
        end
        check(!moved, "R8", "held message changed", int'(moved), 0);
        accept(8'h5B, 4'b0011, "R8");
    endtask

    task automatic t_handshake;
        wr(12, ent(0, 0, 4'b0001, 4'd5, 8'h6C));
        wr(13, ent(0, 0, 4'b0010, 4'd4, 8'h6D));
        @(negedge clk);
        irq[12] = 1'b1; irq[13] = 1'b1;
        @(negedge clk);
        irq[12] = 1'b0; irq[13] = 1'b0;
        @(negedge clk);
        check(msg_vector == 8'h6C, "R9", "first vector", int'(msg_vector), 8'h6C);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        check(msg_valid == 1'b0, "R9", "gap after accept", int'(msg_valid), 0);
        @(negedge clk);
        check(msg_valid == 1'b1, "R9", "next offered", int'(msg_valid), 1);
        accept(8'h6D, 4'b0010, "R9");
        quiet(4, "R9");
    endtask

    task automatic t_collide;
        wr(15, ent(0, 0, 4'b0001, 4'd3, 8'h7F));
        pulse(15);
        @(negedge clk);
        check(msg_valid == 1'b1, "R10", "first offer", int'(msg_valid), 1);
        msg_ready = 1'b1;
        irq[15] = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        irq[15] = 1'b0;
        check(msg_valid == 1'b0, "R10", "gap", int'(msg_valid), 0);
        @(negedge clk);
        check(msg_valid == 1'b1, "R10", "second offer", int'(msg_valid), 1);
        accept(8'h7F, 4'b0001, "R10");
        quiet(4, "R10");
    endtask

    task automatic t_empty_dest;
        wr(16, ent(0, 0, 4'b0000, 4'd6, 8'h80));
        pulse(16);
        quiet(5, "R11");
        wr(16, ent(0, 0, 4'b0100, 4'd6, 8'h80));
        accept(8'h80, 4'b0100, "R11");
    endtask

    task automatic t_bad_index;
        wr(30, ent(0, 0, 4'b1111, 4'd1, 8'h99));
        pulse(14);
        quiet(5, "R3");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_mask();
        t_latency_level();
        t_fixed();
        t_priority();
        t_lowest();
        t_hold();
        t_handshake();
        t_collide();
        t_empty_dest();
        t_bad_index();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule